// File: doc/BRIEF.md
# Multichannel Spread-Spectrum IF Sample Generator

This block synthesises a digital intermediate-frequency sample stream for a satellite-navigation receiver test setup. It has four independent channels. Each channel takes a satellite number, an amplitude and a code phase from a host. The host refreshes the phase only every 4092 samples. Between refreshes the block linearly interpolates the phase at the sample rate, so code and carrier move smoothly.

Every sample, each channel looks up its spreading chip and a quarter-rate carrier value, then scales the product by its amplitude. The four contributions are summed, clipped and offset into an unsigned word for a 10-bit DAC. One clock is one output sample; at the nominal 8.184 MHz sample rate the carrier falls at one quarter of that rate. When a channel gets a new satellite number, it rebuilds its 1023-chip code table from two 10-stage shift registers. It stays silent while the rebuild runs.

Top module: `gps_if_gen`

## Requirements
- R1: After reset, and until the first update tick, `dac_o` is 512 (mid-scale).
- R2: A channel's satellite number, amplitude and phase are taken only in a cycle with `upd_i` high. Changes on those inputs at any other time leave `dac_o` unchanged.
- R3: Phase is counted in 1/32-sample units. Inputs of 261888 or more are first reduced by 261888. On a tick, the running phase is set to the previous host phase. The step becomes floor(d·4096/4092) in 1/4096 units, where d = (new − previous) mod 261888. The previous host phase is then replaced.
- R4: On every other clock the running phase advances by the step and wraps modulo 261888 (one 8184-sample code period).
- R5: The sample index is the integer phase divided by 32. The chip index is the sample index divided by 8. The carrier takes +1, 0, −1, 0 for sample index mod 4 equal to 0, 1, 2, 3.
- R6: The chip comes from the 1023-chip Gold code with G1 feedback at stages 3 and 10, G2 feedback at 2, 3, 6, 8, 9 and 10, and both registers starting at all ones. Satellite value s selects PRN s+1 through its pair of G2 output stages. A chip bit of 0 gives +1 and a bit of 1 gives −1. For PRN 1 the first ten chips are 1100100000.
- R7: A channel contributes chip × carrier × amplitude, with the amplitude as an unsigned 7-bit number.
- R8: A tick that brings a satellite number different from the loaded one starts a code rebuild. The first tick after reset always starts one. The channel contributes 0 for the 1023 clocks that follow. A tick with the same number does not rebuild.
- R9: The channel sum is clipped to −512..511 and offset by +512. It appears on `dac_o` one clock after the phase state that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Host update tick, one clock wide |
| svn_i | input | 20 | Satellite number per channel, 5 bits each, channel 0 in the low bits |
| amp_i | input | 28 | Amplitude per channel, 7 bits each |
| phase_i | input | 72 | Host phase per channel, 18 bits each |
| dac_o | output | 10 | Offset-binary DAC sample |

## Verification
Static phases (two ticks with the same value give a step of zero) freeze each channel on a chosen chip and carrier quarter. These patterns separate errors in code generation and tap selection from carrier mapping, sign, and scaling faults. Four full-scale channels aligned in sign expose the sum and offset path. A satellite change on one channel separates the rebuild mute from an unchanged-number tick. Long ramps, with one ramp crossing the code-period boundary, compare the interpolator and its wrap against a behavioural model on every clock.

// File: rtl/gps_if_pkg.sv
package gps_if_pkg;

    localparam int CODE_LEN  = 1023;
    localparam int SUB_BITS  = 5;
    localparam int CHIP_BITS = 3;
    localparam int SVN_W     = 5;
    localparam int PERIOD    = CODE_LEN << (SUB_BITS + CHIP_BITS);

    // G2 output stage pair (1..10) for satellite value s, PRN s+1
    function automatic logic [7:0] ca_taps(input logic [SVN_W-1:0] s);
        logic [7:0] t;
        case (s)
            5'd0:  t = {4'd2, 4'd6};   5'd1:  t = {4'd3, 4'd7};
            5'd2:  t = {4'd4, 4'd8};   5'd3:  t = {4'd5, 4'd9};
            5'd4:  t = {4'd1, 4'd9};   5'd5:  t = {4'd2, 4'd10};
            5'd6:  t = {4'd1, 4'd8};   5'd7:  t = {4'd2, 4'd9};
            5'd8:  t = {4'd3, 4'd10};  5'd9:  t = {4'd2, 4'd3};
            5'd10: t = {4'd3, 4'd4};   5'd11: t = {4'd5, 4'd6};
            5'd12: t = {4'd6, 4'd7};   5'd13: t = {4'd7, 4'd8};
            5'd14: t = {4'd8, 4'd9};   5'd15: t = {4'd9, 4'd10};
            5'd16: t = {4'd1, 4'd4};   5'd17: t = {4'd2, 4'd5};
            5'd18: t = {4'd3, 4'd6};   5'd19: t = {4'd4, 4'd7};
            5'd20: t = {4'd5, 4'd8};   5'd21: t = {4'd6, 4'd9};
            5'd22: t = {4'd1, 4'd3};   5'd23: t = {4'd4, 4'd6};
            5'd24: t = {4'd5, 4'd7};   5'd25: t = {4'd6, 4'd8};
            5'd26: t = {4'd7, 4'd9};   5'd27: t = {4'd8, 4'd10};
            5'd28: t = {4'd1, 4'd6};   5'd29: t = {4'd2, 4'd7};
            5'd30: t = {4'd3, 4'd8};   default: t = {4'd4, 4'd9};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/gps_phase_interp.sv
module gps_phase_interp
    import gps_if_pkg::*;
#(
    parameter int PHASE_W     = 18,
    parameter int FRAC_W      = 12,
    parameter int UPD_SAMPLES = 4092
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic [PHASE_W-1:0]          phase_i,
    output logic [PHASE_W-SUB_BITS-1:0] samp_o
);
    localparam int ACC_W = PHASE_W + FRAC_W;
    localparam logic [ACC_W-1:0] PERIOD_FX = ACC_W'(PERIOD) << FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [ACC_W-1:0]   step;
        logic [PHASE_W-1:0] prev;
    } interp_t;

    interp_t s_d, s_q;
    logic [PHASE_W-1:0] pin;
    logic [ACC_W-1:0]   diff;
    logic [ACC_W-1:0]   nxt_step;
    logic [ACC_W:0]     adv;

    always_comb begin
        s_d = s_q;
        pin = (phase_i >= PHASE_W'(PERIOD)) ? phase_i - PHASE_W'(PERIOD) : phase_i;
        if (pin >= s_q.prev) begin
            diff = ACC_W'(pin) - ACC_W'(s_q.prev);
        end else begin
            diff = ACC_W'(pin) + ACC_W'(PERIOD) - ACC_W'(s_q.prev);
        end
        nxt_step = (diff << FRAC_W) / ACC_W'(UPD_SAMPLES);
        adv = {1'b0, s_q.acc} + {1'b0, s_q.step};
        if (adv >= {1'b0, PERIOD_FX}) begin
            adv = adv - {1'b0, PERIOD_FX};
        end
        if (tick_i) begin
            s_d.acc  = {s_q.prev, {FRAC_W{1'b0}}};
            s_d.step = nxt_step;
            s_d.prev = pin;
        end else begin
            s_d.acc = adv[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign samp_o = s_q.acc[ACC_W-1 -: (PHASE_W-SUB_BITS)];

    // R4
    acc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.acc < PERIOD_FX);

    // R3
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> s_q.acc == {$past(s_q.prev), {FRAC_W{1'b0}}});

endmodule

// File: rtl/gps_ca_store.sv
module gps_ca_store
    import gps_if_pkg::*;
#(
    parameter int IDX_W = $clog2(CODE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SVN_W-1:0] svn_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             chip_o,
    output logic             busy_o
);
    localparam logic [9:0] G1_MASK = 10'h204;
    localparam logic [9:0] G2_MASK = 10'h3A6;

    typedef struct packed {
        logic [CODE_LEN-1:0] mem;
        logic [9:0]          g1;
        logic [9:0]          g2;
        logic [IDX_W-1:0]    cnt;
        logic [3:0]          ta;
        logic [3:0]          tb;
        logic                busy;
    } store_t;

    store_t s_d, s_q;
    logic   gen_bit;

    always_comb begin
        s_d = s_q;
        gen_bit = s_q.g1[9] ^ s_q.g2[4'(s_q.ta - 4'd1)] ^ s_q.g2[4'(s_q.tb - 4'd1)];
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.g1   = '1;
            s_d.g2   = '1;
            {s_d.ta, s_d.tb} = ca_taps(svn_i);
        end else if (s_q.busy) begin
            s_d.mem[s_q.cnt] = gen_bit;
            s_d.g1 = {s_q.g1[8:0], ^(s_q.g1 & G1_MASK)};
            s_d.g2 = {s_q.g2[8:0], ^(s_q.g2 & G2_MASK)};
            if (s_q.cnt == IDX_W'(CODE_LEN - 1)) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.g1   <= '1;
            s_q.g2   <= '1;
            s_q.ta   <= 4'd1;
            s_q.tb   <= 4'd2;
        end else begin
            s_q <= s_d;
        end
    end

    assign chip_o = s_q.mem[rd_idx_i];
    assign busy_o = s_q.busy;

    // R8
    load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.cnt < IDX_W'(CODE_LEN));

    // R8
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o && s_q.cnt == '0);

    // R8
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/gps_sample_sum.sv
module gps_sample_sum #(
    parameter int NUM_CH = 4,
    parameter int TERM_W = 8,
    parameter int OUT_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*TERM_W-1:0] terms_i,
    output logic [OUT_W-1:0]         dac_o
);
    localparam int SUM_W = TERM_W + $clog2(NUM_CH) + 1;
    localparam int MID   = 1 << (OUT_W - 1);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(MID - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = SUM_W'(-MID);
    localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(MID);

    typedef struct packed {
        logic [OUT_W-1:0] dac;
    } sum_t;

    sum_t s_d, s_q;
    logic signed [SUM_W-1:0] total;
    logic signed [SUM_W-1:0] clip;

    always_comb begin
        s_d   = s_q;
        total = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            total = total + SUM_W'($signed(terms_i[i*TERM_W +: TERM_W]));
        end
        if (total > SAT_HI) begin
            clip = SAT_HI;
        end else if (total < SAT_LO) begin
            clip = SAT_LO;
        end else begin
            clip = total;
        end
        s_d.dac = {~clip[OUT_W-1], clip[OUT_W-2:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.dac <= MID_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_o = s_q.dac;

    // R9
    zero_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (terms_i == '0) |=> dac_o == MID_CODE);

endmodule

// File: rtl/gps_if_gen.sv
module gps_if_gen
    import gps_if_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int PHASE_W     = 18,
    parameter int AMP_W       = 7,
    parameter int OUT_W       = 10,
    parameter int FRAC_W      = 12,
    parameter int UPD_SAMPLES = 4092
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_i,
    input  logic [NUM_CH*SVN_W-1:0]   svn_i,
    input  logic [NUM_CH*AMP_W-1:0]   amp_i,
    input  logic [NUM_CH*PHASE_W-1:0] phase_i,
    output logic [OUT_W-1:0]          dac_o
);
    localparam int TERM_W = AMP_W + 1;
    localparam int IDX_W  = $clog2(CODE_LEN);
    localparam int SAMP_W = PHASE_W - SUB_BITS;
    localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(1 << (OUT_W - 1));

    logic [NUM_CH*TERM_W-1:0] terms;
    logic [NUM_CH-1:0]        busy;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        typedef struct packed {
            logic [AMP_W-1:0] amp;
            logic [SVN_W-1:0] svn;
            logic             valid;
        } chan_t;

        chan_t r_d, r_q;
        logic [SVN_W-1:0]         svn_in;
        logic                     start;
        logic [SAMP_W-1:0]        samp;
        logic                     chip;
        logic signed [TERM_W-1:0] mag;
        logic signed [TERM_W-1:0] carr;
        logic signed [TERM_W-1:0] term;
        logic                     unused_bits;

        assign svn_in = svn_i[c*SVN_W +: SVN_W];

        always_comb begin
            r_d   = r_q;
            start = upd_i && (!r_q.valid || svn_in != r_q.svn);
            if (upd_i) begin
                r_d.amp   = amp_i[c*AMP_W +: AMP_W];
                r_d.svn   = svn_in;
                r_d.valid = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        gps_phase_interp #(
            .PHASE_W     (PHASE_W),
            .FRAC_W      (FRAC_W),
            .UPD_SAMPLES (UPD_SAMPLES)
        ) u_interp (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (upd_i),
            .phase_i (phase_i[c*PHASE_W +: PHASE_W]),
            .samp_o  (samp)
        );

        gps_ca_store #(
            .IDX_W (IDX_W)
        ) u_code (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start),
            .svn_i    (svn_in),
            .rd_idx_i (samp[CHIP_BITS +: IDX_W]),
            .chip_o   (chip),
            .busy_o   (busy[c])
        );

        assign unused_bits = ^samp[CHIP_BITS-1:2];

        always_comb begin
            mag = $signed({1'b0, r_q.amp});
            case (samp[1:0])
                2'd0:    carr = mag;
                2'd2:    carr = -mag;
                default: carr = '0;
            endcase
            term = chip ? -carr : carr;
            if (busy[c]) begin
                term = '0;
            end
        end

        assign terms[c*TERM_W +: TERM_W] = term;
    end

    gps_sample_sum #(
        .NUM_CH (NUM_CH),
        .TERM_W (TERM_W),
        .OUT_W  (OUT_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .terms_i (terms),
        .dac_o   (dac_o)
    );

    // R8
    all_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |=> dac_o == MID_CODE);

endmodule

// File: tb/gps_if_gen_tb_top.sv
module gps_if_gen_tb_top;

    localparam int NCH = 4;
    localparam int P   = 261888;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd = 1'b0;
    logic [19:0] svn_v = '0;
    logic [27:0] amp_v = '0;
    logic [71:0] ph_v  = '0;
    logic [9:0]  dac;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gps_if_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .svn_i   (svn_v),
        .amp_i   (amp_v),
        .phase_i (ph_v),
        .dac_o   (dac)
    );

    // ---------------- behavioural reference ----------------
    int ta[32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
    int tb[32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};

    longint m_acc[NCH];
    longint m_step[NCH];
    int     m_prev[NCH];
    int     m_amp[NCH];
    int     m_svn[NCH];
    int     m_busy[NCH];
    bit     m_valid[NCH];
    bit     m_code[NCH][1023];
    int     exp_dac = 512;

    task automatic build_code(input int ch, input int s);
        int g1[11];
        int g2[11];
        for (int i = 1; i <= 10; i++) begin
            g1[i] = 1;
            g2[i] = 1;
        end
        for (int k = 0; k < 1023; k++) begin
            int f1;
            int f2;
            m_code[ch][k] = bit'(g1[10] ^ g2[ta[s]] ^ g2[tb[s]]);
            f1 = g1[3] ^ g1[10];
            f2 = g2[2] ^ g2[3] ^ g2[6] ^ g2[8] ^ g2[9] ^ g2[10];
            for (int i = 10; i >= 2; i--) begin
                g1[i] = g1[i-1];
                g2[i] = g2[i-1];
            end
            g1[1] = f1;
            g2[1] = f2;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_acc[c] = 0; m_step[c] = 0; m_prev[c] = 0; m_amp[c] = 0;
                m_svn[c] = 0; m_busy[c] = 0; m_valid[c] = 0;
            end
            exp_dac = 512;
        end else begin
            int sum;
            sum = 0;
            for (int c = 0; c < NCH; c++) begin
                if (m_busy[c] == 0) begin
                    longint idx;
                    int car;
                    int sg;
                    idx = (m_acc[c] / 4096) / 32;
                    car = (idx % 4 == 0) ? 1 : ((idx % 4 == 2) ? -1 : 0);
                    sg  = m_code[c][int'(idx / 8)] ? -1 : 1;
                    sum += sg * car * m_amp[c];
                end
            end
            if (sum > 511) sum = 511;
            if (sum < -512) sum = -512;
            exp_dac = sum + 512;
            for (int c = 0; c < NCH; c++) begin
                if (m_busy[c] > 0) m_busy[c]--;
                if (upd) begin
                    int pin;
                    int d;
                    int s;
                    pin = int'(ph_v[c*18 +: 18]);
                    if (pin >= P) pin -= P;
                    d = (pin >= m_prev[c]) ? pin - m_prev[c] : pin + P - m_prev[c];
                    m_acc[c]  = longint'(m_prev[c]) * 4096;
                    m_step[c] = (longint'(d) * 4096) / 4092;
                    m_prev[c] = pin;
                    m_amp[c]  = int'(amp_v[c*7 +: 7]);
                    s = int'(svn_v[c*5 +: 5]);
                    if (!m_valid[c] || s != m_svn[c]) begin
                        build_code(c, s);
                        m_busy[c] = 1023;
                    end
                    m_svn[c] = s;
                    m_valid[c] = 1'b1;
                end else begin
                    m_acc[c] += m_step[c];
                    if (m_acc[c] >= longint'(P) * 4096) m_acc[c] -= longint'(P) * 4096;
                end
            end
        end
    end

    // cycle-by-cycle comparison: R3 R4 R5 R6 R7 R8 R9
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(dac) != exp_dac) begin
                errors++;
                $display("FAIL R3/R4/R5/R6/R7/R8/R9 model t=%0t actual %0d expected %0d",
                         $time, dac, exp_dac);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic set_ch(input int ch, input int s, input int a, input int ph);
        svn_v[ch*5 +: 5]  = 5'(s);
        amp_v[ch*7 +: 7]  = 7'(a);
        ph_v[ch*18 +: 18] = 18'(ph);
    endtask

    task automatic tick();
        @(negedge clk) upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int prn1_bits[10] = '{1,1,0,0,1,0,0,0,0,0};
    bit done = 1'b0;

    initial begin
        settle(4);
        check("R1 reset mid-scale", int'(dac), 512);
        @(negedge clk) rst_n = 1'b1;
        settle(3);
        check("R1 idle before tick", int'(dac), 512);

        // channel 0 PRN1 alone; others loaded with silent amplitude
        set_ch(0, 0, 100, 0);
        set_ch(1, 1, 0, 0);
        set_ch(2, 2, 0, 0);
        set_ch(3, 3, 0, 0);
        tick();
        settle(300);
        check("R8 muted during first rebuild", int'(dac), 512);
        settle(740);

        // R6: freeze on chips 0..9 at carrier quarter 0
        for (int k = 0; k < 10; k++) begin
            set_ch(0, 0, 100, k * 256);
            tick();
            tick();
            settle(2);
            check("R6 PRN1 chip", int'(dac), prn1_bits[k] ? 412 : 612);
        end

        // R5: carrier quarters on chip 0 (bit 1 -> -1)
        set_ch(0, 0, 100, 32); tick(); tick(); settle(2);
        check("R5 quarter 1 zero", int'(dac), 512);
        set_ch(0, 0, 100, 64); tick(); tick(); settle(2);
        check("R5 quarter 2 inverted", int'(dac), 612);
        set_ch(0, 0, 100, 96); tick(); tick(); settle(2);
        check("R5 quarter 3 zero", int'(dac), 512);

        // R7 / R9: four full-scale channels at chip 0
        for (int c = 0; c < NCH; c++) set_ch(c, c, 127, 0);
        tick(); tick(); settle(2);
        check("R9 R7 four channels negative", int'(dac), 4);
        for (int c = 0; c < NCH; c++) set_ch(c, c, 127, 64);
        tick(); tick(); settle(2);
        check("R9 R7 four channels positive", int'(dac), 1020);

        // R3: out-of-range phase reduced by the period
        for (int c = 0; c < NCH; c++) set_ch(c, c, 127, 0);
        set_ch(0, 0, 127, P);
        tick(); tick(); settle(2);
        check("R3 phase reduction", int'(dac), 4);

        // R2: inputs ignored without a tick
        for (int c = 0; c < NCH; c++) set_ch(c, c + 7, 10, 5000);
        settle(30);
        check("R2 no tick no change", int'(dac), 4);
        for (int c = 0; c < NCH; c++) set_ch(c, c, 127, 0);

        // R8: rebuild on a changed number, none on an unchanged one
        set_ch(1, 9, 127, 0);
        tick();
        settle(200);
        check("R8 changed channel muted", int'(dac), 131);
        settle(900);
        check("R8 rebuilt channel back", int'(dac), 4);
        tick();
        settle(3);
        check("R8 same number no mute", int'(dac), 4);

        // R3 R4: interpolated ramps, channel 3 crossing the wrap
        set_ch(0, 4, 40, 1000);
        set_ch(1, 9, 55, 70000);
        set_ch(2, 2, 33, 150000);
        set_ch(3, 3, 60, 200000);
        tick();
        settle(1100);
        tick();
        settle(4091);
        set_ch(0, 4, 40, 1000 + 130944 + 37);
        set_ch(1, 9, 55, 70000 + 130944 - 211);
        set_ch(2, 2, 33, 150000 + 130944 + 900);
        set_ch(3, 3, 60, (200000 + 130944 + 5) % P);
        tick();
        settle(4091);
        set_ch(0, 4, 40, (1000 + 2 * 130944 + 80) % P);
        set_ch(1, 9, 55, (70000 + 2 * 130944) % P);
        set_ch(2, 2, 33, (150000 + 2 * 130944 + 1700) % P);
        set_ch(3, 3, 60, (200000 + 2 * 130944 - 40) % P);
        tick();
        settle(8200);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule